// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Modulo Baud Divider

This block is a full-duplex asynchronous serial port using NRZ framing. A serial frame is one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. A single modulo divider turns the system clock into a tick at sixteen times the bit rate. The transmitter and the receiver both run from that tick.

Each direction holds two words. On the transmit side, the holding register can take the next byte while the shift register sends the current one. On the receive side, a finished frame lands in a receive register that software reads while the next frame is already shifting in. The receiver takes three samples around the middle of each bit and keeps the majority value. It raises a noise flag when those samples disagree. Software can put the receiver to sleep, so that it drops traffic until one of two wake events occurs. In idle mode, the event is a quiet line lasting a full frame. In address-mark mode, the event is a frame whose top data bit is set.

Software reaches the block over a small byte-wide register bus. One interrupt line combines three sources: transmit-buffer-free, line-quiet and receive-ready. Each source has its own enable.

Top module: `aser_core`

## Requirements
- R1: After reset, txd is 1, irq is 0, the control and divisor registers read 0, and the status register reads 0x03 (bit0 transmit buffer free = 1, bit1 transmitter quiet = 1, all other status bits 0).
- R2: The divisor is 13 bits wide. Address 0 holds bits 7:0 and address 1 holds bits 12:8, so the upper three bits of address 1 read 0. The tick period is the divisor value in clocks. One bit lasts 16 ticks. A divisor of 0 stops all serial activity.
- R3: A transmitted frame is a 0 start bit, then the 8 data bits LSB first, then a parity bit if control bit2 is set, then a 1 stop bit. The parity is even when control bit3 is 0 and odd when it is 1.
- R4: Writing the data register (address 5) clears status bit0. Bit0 sets again once the byte moves to the shifter. Status bit1 is 1 only when the holding register is empty and no frame is on the line. Two back-to-back writes come out in order.
- R5: While control bit0 (transmit enable) is 0, no frame starts, txd stays 1 and a written byte is held. Setting the bit sends the held byte.
- R6: A received frame sets status bit2 and puts its data at address 5. A bus read of address 5 clears bit2 and the error bits 3 to 6.
- R7: Each bit takes the majority of samples 7, 8 and 9 of its 16 ticks. Any disagreement within a frame sets status bit3 for that frame.
- R8: With parity enabled, a parity mismatch sets status bit4. A stop bit sampled as 0 sets status bit5.
- R9: A frame that completes while status bit2 is still set is dropped and sets status bit6. The earlier data stays readable.
- R10: While control bit1 (receive enable) is 0, incoming frames change no status bit.
- R11: Writing control bit4 = 1 puts the receiver to sleep. The sleep state reads back in control bit4 and in status bit7. With control bit5 = 0, frames are dropped until the line has stayed at 1 for a full frame time (16 ticks per frame bit). After that the receiver wakes.
- R12: With control bit5 = 1, a sleeping receiver ignores idle time and drops frames whose data bit 7 is 0. A frame with bit 7 set wakes the receiver and is received.
- R13: irq is the OR of three terms: status bit0 AND control bit6, status bit1 AND control bit7, and status bit2 AND bit0 of the register at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the clock edge that captures the strobe, and status is sampled at the falling edge that follows. A queued byte moves to the shifter on the next tick, so the holding-free flag is checked one clock after the write and again a few ticks later. The receiver's three samples fall on offsets 8, 9 and 10 clocks into each driven bit (divisor 1): two synchronizer stages plus the start-detect register. Glitches are placed on those offsets, and receive status is read only after the whole stop bit has been driven. Transmit bits are sampled at the centre of each 16-tick bit, counted from the first falling edge that shows the start bit.

// File: rtl/aser_pkg.sv
package aser_pkg;
   // register addresses of the byte bus
   localparam logic [2:0] ADR_DIV_LO = 3'd0;
   localparam logic [2:0] ADR_DIV_HI = 3'd1;
   localparam logic [2:0] ADR_CTL    = 3'd2;
   localparam logic [2:0] ADR_IEN    = 3'd3;
   localparam logic [2:0] ADR_STAT   = 3'd4;
   localparam logic [2:0] ADR_DATA   = 3'd5;
   // ticks per serial bit
   localparam int unsigned OVS = 16;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/aser_baud.sv
module aser_baud #(
   parameter int unsigned DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic             wrap;

   assign wrap = (div != '0) && (cnt >= div - DIV_W'(1));
   assign tick = wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (div == '0)   cnt <= '0;
      else if (wrap)        cnt <= '0;
      else                  cnt <= cnt + DIV_W'(1);
   end

   // R2: with a divisor above one, two ticks are never adjacent
   assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div > DIV_W'(1)) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/aser_tx.sv
module aser_tx #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              txd,
   output logic              tdre,
   output logic              tc
);
   import aser_pkg::*;
   localparam int unsigned FW = DATA_W + 3;
   localparam int unsigned BW = $clog2(FW + 1);

   logic [DATA_W-1:0] buf_q;
   logic              buf_full, busy, load, use_par, par_bit;
   logic [FW-1:0]     sh, frame;
   logic [3:0]        sub;
   logic [BW-1:0]     bit_n, last_n;

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par = par_en;
         assign par_bit = (^buf_q) ^ par_odd;
      end else begin : g_nopar
         assign use_par = 1'b0;
         assign par_bit = 1'b0;
      end
   endgenerate

   assign frame = use_par ? {1'b1, par_bit, buf_q, 1'b0} : {2'b11, buf_q, 1'b0};
   assign load  = tick && !busy && buf_full && en;
   assign txd   = busy ? sh[0] : 1'b1;
   assign tdre  = !buf_full;
   assign tc    = !buf_full && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q    <= '0;
         buf_full <= 1'b0;
         busy     <= 1'b0;
         sh       <= '1;
         sub      <= '0;
         bit_n    <= '0;
         last_n   <= '0;
      end else begin
         if (wr) begin
            buf_q    <= wdata;
            buf_full <= 1'b1;
         end else if (load) begin
            buf_full <= 1'b0;
         end
         if (load) begin
            sh     <= frame;
            busy   <= 1'b1;
            sub    <= '0;
            bit_n  <= '0;
            last_n <= use_par ? BW'(FW - 1) : BW'(FW - 2);
         end else if (busy && tick) begin
            sub <= sub + 4'd1;
            if (sub == 4'(OVS - 1)) begin
               if (bit_n == last_n) busy <= 1'b0;
               else begin
                  bit_n <= bit_n + BW'(1);
                  sh    <= {1'b1, sh[FW-1:1]};
               end
            end
         end
      end
   end

   // R4: moving a byte into the shifter frees the holding register
   assert_load_frees_buffer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr) |=> tdre);
   // R3: every frame ends on a high stop bit
   assert_stop_bit_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));
endmodule

// File: rtl/aser_rx.sv
module aser_rx #(
   parameter int unsigned DATA_W     = 8,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              wake_addr,
   input  logic              sleep_set,
   input  logic              rd,
   input  logic              rxd,
   output logic [DATA_W-1:0] data,
   output logic              rdrf,
   output logic              noise,
   output logic              perr,
   output logic              ferr,
   output logic              ovr,
   output logic              asleep
);
   import aser_pkg::*;
   localparam int unsigned FB_MAX = DATA_W + 3;
   localparam int unsigned BW     = $clog2(FB_MAX + 1);
   localparam int unsigned IW     = $clog2(OVS * FB_MAX + 1);

   logic [1:0]        sy;
   logic              rx_s, busy, s7, s8, par_s, nacc, use_par;
   logic              maj, dis, at_smp, fin, accept, fr_perr;
   logic [3:0]        sub;
   logic [BW-1:0]     bit_n, stop_n;
   logic [DATA_W-1:0] dat;
   logic [IW-1:0]     idle_cnt, idle_lim;

   generate
      if (HAS_PARITY) begin : g_par
         assign use_par = par_en;
      end else begin : g_nopar
         assign use_par = 1'b0;
      end
   endgenerate

   assign rx_s     = sy[1];
   assign stop_n   = use_par ? BW'(DATA_W + 2) : BW'(DATA_W + 1);
   assign idle_lim = use_par ? IW'(OVS * (DATA_W + 3)) : IW'(OVS * (DATA_W + 2));
   assign maj      = maj3(s7, s8, rx_s);
   assign dis      = !((s7 == s8) && (s8 == rx_s));
   assign at_smp   = tick && busy && en && (sub == 4'd9);
   assign fin      = at_smp && (bit_n == stop_n);
   assign fr_perr  = use_par && (((^dat) ^ par_s) != par_odd);
   assign accept   = fin && (!asleep || (wake_addr && dat[DATA_W-1]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= 2'b11;
      else        sy <= {sy[0], rxd};
   end

   // frame sampling
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sub   <= '0;
         bit_n <= '0;
         dat   <= '0;
         s7    <= 1'b1;
         s8    <= 1'b1;
         par_s <= 1'b0;
         nacc  <= 1'b0;
      end else if (!en) begin
         busy <= 1'b0;
      end else if (tick) begin
         if (!busy) begin
            if (!rx_s) begin
               busy  <= 1'b1;
               sub   <= '0;
               bit_n <= '0;
               nacc  <= 1'b0;
            end
         end else begin
            sub <= sub + 4'd1;
            if (sub == 4'd7) s7 <= rx_s;
            if (sub == 4'd8) s8 <= rx_s;
            if (sub == 4'(OVS - 1)) bit_n <= bit_n + BW'(1);
            if (sub == 4'd9) begin
               if (bit_n == '0) begin
                  if (maj) busy <= 1'b0;
                  nacc <= dis;
               end else if (bit_n <= BW'(DATA_W)) begin
                  dat  <= {maj, dat[DATA_W-1:1]};
                  nacc <= nacc | dis;
               end else if (bit_n != stop_n) begin
                  par_s <= maj;
                  nacc  <= nacc | dis;
               end else begin
                  busy <= 1'b0;
               end
            end
         end
      end
   end

   // receive register, flags and sleep state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data     <= '0;
         rdrf     <= 1'b0;
         noise    <= 1'b0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         ovr      <= 1'b0;
         asleep   <= 1'b0;
         idle_cnt <= '0;
      end else begin
         if (rd) begin
            rdrf  <= 1'b0;
            ovr   <= 1'b0;
            noise <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
         end
         if (accept) begin
            if (rdrf && !rd) ovr <= 1'b1;
            else begin
               data  <= dat;
               rdrf  <= 1'b1;
               noise <= nacc | dis;
               perr  <= fr_perr;
               ferr  <= !maj;
            end
         end
         if (sleep_set) asleep <= 1'b1;
         else if (asleep && fin && wake_addr && dat[DATA_W-1]) asleep <= 1'b0;
         else if (asleep && !wake_addr && idle_cnt >= idle_lim) asleep <= 1'b0;
         if (!asleep || wake_addr || busy || !rx_s || !en) idle_cnt <= '0;
         else if (tick && idle_cnt < idle_lim) idle_cnt <= idle_cnt + IW'(1);
      end
   end

   // R9: an overrunning frame leaves the held data untouched
   assert_overrun_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rdrf && !rd) |=> ($stable(data) && ovr));
   // R11: in idle-wake mode nothing arrives while asleep
   assert_asleep_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdrf) |-> (!$past(asleep) || $past(wake_addr)));
   // R10: a disabled receiver is never mid-frame
   assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
   // R7: the noise flag only rises together with held data
   assert_noise_with_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(noise) |-> rdrf);
endmodule

// File: rtl/aser_core.sv
module aser_core #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DIV_W      = 13,
   parameter bit          HAS_PARITY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       rxd,
   output logic       txd,
   output logic       irq
);
   import aser_pkg::*;

   generate
      if (DATA_W < 5 || DATA_W > 8) begin : g_bad_data
         $error("aser_core: DATA_W must lie in 5..8");
      end
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("aser_core: DIV_W must lie in 9..16");
      end
   endgenerate

   logic [DIV_W-1:0]  div_q;
   logic              tx_en, rx_en, par_en, par_odd, wake_addr, ie_tdre, ie_tc, ie_rx;
   logic              tick, tdre, tc, rdrf, noise, perr, ferr, ovr, asleep;
   logic              tx_wr, rx_rd, sleep_set;
   logic [DATA_W-1:0] rx_data;

   assign tx_wr     = bus_wr && bus_addr == ADR_DATA;
   assign rx_rd     = bus_rd && bus_addr == ADR_DATA;
   assign sleep_set = bus_wr && bus_addr == ADR_CTL && bus_wdata[4];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         tx_en     <= 1'b0;
         rx_en     <= 1'b0;
         par_en    <= 1'b0;
         par_odd   <= 1'b0;
         wake_addr <= 1'b0;
         ie_tdre   <= 1'b0;
         ie_tc     <= 1'b0;
         ie_rx     <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            ADR_DIV_LO: div_q[7:0] <= bus_wdata;
            ADR_DIV_HI: div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
            ADR_CTL: begin
               tx_en     <= bus_wdata[0];
               rx_en     <= bus_wdata[1];
               par_en    <= bus_wdata[2];
               par_odd   <= bus_wdata[3];
               wake_addr <= bus_wdata[5];
               ie_tdre   <= bus_wdata[6];
               ie_tc     <= bus_wdata[7];
            end
            ADR_IEN: ie_rx <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         ADR_DIV_LO: bus_rdata = div_q[7:0];
         ADR_DIV_HI: bus_rdata = 8'(div_q >> 8);
         ADR_CTL:    bus_rdata = {ie_tc, ie_tdre, wake_addr, asleep, par_odd, par_en, rx_en, tx_en};
         ADR_IEN:    bus_rdata = {7'd0, ie_rx};
         ADR_STAT:   bus_rdata = {asleep, ovr, ferr, perr, noise, rdrf, tc, tdre};
         ADR_DATA:   bus_rdata = 8'(rx_data);
         default:    bus_rdata = 8'd0;
      endcase
   end

   assign irq = (tdre & ie_tdre) | (tc & ie_tc) | (rdrf & ie_rx);

   aser_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

   aser_tx #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_en), .par_en(par_en),
      .par_odd(par_odd), .wr(tx_wr), .wdata(bus_wdata[DATA_W-1:0]),
      .txd(txd), .tdre(tdre), .tc(tc));

   aser_rx #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_en), .par_en(par_en),
      .par_odd(par_odd), .wake_addr(wake_addr), .sleep_set(sleep_set),
      .rd(rx_rd), .rxd(rxd), .data(rx_data), .rdrf(rdrf), .noise(noise),
      .perr(perr), .ferr(ferr), .ovr(ovr), .asleep(asleep));
endmodule

// File: tb/sim_aser_core.sv
module sim_aser_core;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0] bus_addr = 3'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       rxd_drv = 1'b1, loop = 1'b0, rxd_w, txd, irq;
   int         n_vec = 0, n_bad = 0;

   assign rxd_w = loop ? txd : rxd_drv;
   always #(CLK_P/2) clk = ~clk;

   aser_core u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxd(rxd_w), .txd(txd), .irq(irq));

   function automatic logic [7:0] ctl(input bit tx, rx, pe, po, wk, wa, itd, itc);
      return {itc, itd, wa, wk, po, pe, rx, tx};
   endfunction
   function automatic logic par_of(input logic [7:0] d, input bit odd);
      return (^d) ^ odd;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask
   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask
   task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask
   task automatic peek(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; #1 d = bus_rdata;
   endtask

   // drive one frame at divisor 1; glitch gw clocks ending at offset 9 of frame bit gbit
   task automatic send(input logic [7:0] d, input bit up, input bit odd, input bit badp,
                       input bit stop, input int gbit, input int gw);
      logic b [11];
      int   n;
      b[0] = 1'b0;
      for (int i = 0; i < 8; i++) b[i+1] = d[i];
      b[9] = par_of(d, odd) ^ badp;
      if (up) begin b[10] = stop; n = 11; end
      else begin b[9] = stop; n = 10; end
      for (int i = 0; i < n; i++)
         for (int j = 0; j < 16; j++) begin
            @(negedge clk);
            rxd_drv = b[i] ^ ((i == gbit) && (j <= 9) && (j >= 10 - gw));
         end
      @(negedge clk); rxd_drv = 1'b1;
      clks(4);
   endtask

   task automatic capture(input int dv, input bit up, output logic [7:0] d,
                          output logic p, output logic s);
      while (txd !== 1'b0) @(negedge clk);
      clks(8 * dv);
      chk("R3 start bit", txd, 1'b0);
      for (int i = 0; i < 8; i++) begin clks(16 * dv); d[i] = txd; end
      p = 1'b0;
      if (up) begin clks(16 * dv); p = txd; end
      clks(16 * dv); s = txd;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v, d1, d2;
      logic       p1, s1, p2, s2;
      int         cnt;
      int unsigned seed;
      seed = 32'h5eed;
      v = 8'($urandom(seed));

      clks(5); rst_n = 1'b1; clks(1);
      // R1 reset state
      peek(3'd4, v); chk("R1 status", v, 8'h03);
      peek(3'd2, v); chk("R1 ctl", v, 8'h00);
      peek(3'd0, v); chk("R1 div", v, 8'h00);
      chk("R1 txd", txd, 1'b1);
      chk("R1 irq", irq, 1'b0);

      // R2 upper divisor bits
      wr(3'd1, 8'hFF); rdreg(3'd1, v); chk("R2 div hi width", v, 8'h1F);
      wr(3'd1, 8'h00); wr(3'd0, 8'd1);
      wr(3'd2, ctl(1,1,0,0,0,0,0,0));

      // R4 double buffer order and flags
      fork
         begin
            capture(1, 0, d1, p1, s1);
            capture(1, 0, d2, p2, s2);
         end
         begin
            wr(3'd5, 8'hA7);
            peek(3'd4, v); chk("R4 tdre clear after write", v[0], 1'b0);
            clks(3);
            peek(3'd4, v); chk("R4 tdre set, tc clear", v[1:0], 2'b01);
            wr(3'd5, 8'h3C);
            peek(3'd4, v); chk("R4 both busy", v[1:0], 2'b00);
         end
      join
      chk("R4 first byte", d1, 8'hA7); chk("R4 second byte", d2, 8'h3C);
      chk("R3 stop", s1 & s2, 1'b1);
      clks(20);
      peek(3'd4, v); chk("R4 quiet after both", v[1:0], 2'b11);

      // R3 parity odd and even
      wr(3'd2, ctl(1,1,1,1,0,0,0,0));
      fork capture(1, 1, d1, p1, s1); wr(3'd5, 8'h5A); join
      chk("R3 odd data", d1, 8'h5A); chk("R3 odd parity", p1, par_of(8'h5A, 1));
      wr(3'd2, ctl(1,1,1,0,0,0,0,0));
      fork capture(1, 1, d1, p1, s1); wr(3'd5, 8'h07); join
      chk("R3 even parity", p1, par_of(8'h07, 0)); chk("R3 stop after parity", s1, 1'b1);
      clks(20);

      // R2 bit period: start plus 8 zeros at divisor 5
      wr(3'd2, ctl(1,1,0,0,0,0,0,0)); wr(3'd0, 8'd5);
      wr(3'd5, 8'h00);
      while (txd !== 1'b0) @(negedge clk);
      cnt = 0;
      while (txd === 1'b0) begin cnt++; @(negedge clk); end
      chk("R2 low time 9 bits x 16 x 5", cnt, 720);
      clks(200);
      // R2 divisor 0 halts
      wr(3'd0, 8'd0); wr(3'd5, 8'h3C); clks(300);
      chk("R2 halted txd", txd, 1'b1);
      peek(3'd4, v); chk("R2 halted tdre", v[0], 1'b0);
      fork capture(1, 0, d1, p1, s1); wr(3'd0, 8'd1); join
      chk("R2 resumed byte", d1, 8'h3C);
      clks(20);

      // R5 transmit enable
      wr(3'd2, ctl(0,1,0,0,0,0,0,0)); wr(3'd5, 8'h99); clks(200);
      chk("R5 txd idle while disabled", txd, 1'b1);
      peek(3'd4, v); chk("R5 byte held", v[0], 1'b0);
      fork capture(1, 0, d1, p1, s1); wr(3'd2, ctl(1,1,0,0,0,0,0,0)); join
      chk("R5 held byte sent", d1, 8'h99);
      clks(20);

      // R13 interrupt sources
      wr(3'd2, ctl(1,1,0,0,0,0,0,1));
      chk("R13 tc irq idle", irq, 1'b1);
      wr(3'd5, 8'h42);
      chk("R13 no irq while busy", irq, 1'b0);
      clks(200);
      chk("R13 tc irq after frame", irq, 1'b1);
      wr(3'd2, ctl(1,1,0,0,0,0,0,0)); wr(3'd3, 8'h01);
      chk("R13 quiet", irq, 1'b0);
      send(8'hC3, 0, 0, 0, 1, -1, 0);
      chk("R13 rx irq", irq, 1'b1);
      // R6 basic receive
      peek(3'd4, v); chk("R6 ready", v[2], 1'b1);
      rdreg(3'd5, v); chk("R6 data", v, 8'hC3);
      peek(3'd4, v); chk("R6 ready cleared", v[2], 1'b0);
      chk("R13 rx irq cleared", irq, 1'b0);
      wr(3'd3, 8'h00);

      // R7 noise and majority
      send(8'hA5, 0, 0, 0, 1, 4, 1);
      peek(3'd4, v); chk("R7 noise single glitch", v[3], 1'b1);
      rdreg(3'd5, v); chk("R7 data kept by majority", v, 8'hA5);
      send(8'hA5, 0, 0, 0, 1, 1, 2);
      peek(3'd4, v); chk("R7 noise double glitch", v[3], 1'b1);
      rdreg(3'd5, v); chk("R7 majority flips bit0", v, 8'hA4);
      send(8'h3E, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R7 clean frame no noise", v[3], 1'b0);
      rdreg(3'd5, v);

      // R8 parity and framing errors
      wr(3'd2, ctl(1,1,1,0,0,0,0,0));
      send(8'h0F, 1, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R8 good parity", v[5:4], 2'b00); rdreg(3'd5, v);
      send(8'h0F, 1, 0, 1, 1, -1, 0);
      peek(3'd4, v); chk("R8 parity error", v[5:4], 2'b01); rdreg(3'd5, v);
      send(8'h0F, 1, 0, 0, 0, -1, 0);
      clks(30);
      peek(3'd4, v); chk("R8 framing error", v[5:4], 2'b10);
      rdreg(3'd5, v); chk("R8 data with framing error", v, 8'h0F);
      wr(3'd2, ctl(1,1,0,0,0,0,0,0));

      // R9 overrun
      send(8'h11, 0, 0, 0, 1, -1, 0);
      send(8'h22, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R9 overrun flag", v[6], 1'b1);
      rdreg(3'd5, v); chk("R9 first data kept", v, 8'h11);
      peek(3'd4, v); chk("R9 cleared by read", v[6], 1'b0);

      // R10 receive disabled
      wr(3'd2, ctl(1,0,0,0,0,0,0,0));
      send(8'h77, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R10 nothing received", v[7:2], 6'd0);
      wr(3'd2, ctl(1,1,0,0,0,0,0,0));

      // R11 idle-line wake
      wr(3'd2, ctl(1,1,0,0,1,0,0,0));
      peek(3'd2, v); chk("R11 asleep readback", v[4], 1'b1);
      send(8'h33, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R11 frame dropped", {v[7], v[2]}, 2'b10);
      clks(100);
      peek(3'd4, v); chk("R11 still asleep", v[7], 1'b1);
      clks(100);
      peek(3'd4, v); chk("R11 woke after idle frame", v[7], 1'b0);
      send(8'h5A, 0, 0, 0, 1, -1, 0);
      rdreg(3'd5, v); chk("R11 frame after wake", v, 8'h5A);

      // R12 address-mark wake
      wr(3'd2, ctl(1,1,0,0,1,1,0,0));
      send(8'h12, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R12 non-mark dropped", {v[7], v[2]}, 2'b10);
      clks(300);
      peek(3'd4, v); chk("R12 idle does not wake", v[7], 1'b1);
      send(8'h85, 0, 0, 0, 1, -1, 0);
      peek(3'd4, v); chk("R12 mark wakes", {v[7], v[2]}, 2'b01);
      rdreg(3'd5, v); chk("R12 mark data", v, 8'h85);

      // R3/R6 random loopback
      loop = 1'b1;
      for (int it = 0; it < 30; it++) begin
         logic [7:0] dat;
         int         dv;
         bit         pe, po;
         dat = 8'($urandom);
         dv  = 1 + int'($urandom % 3);
         pe  = 1'($urandom); po = 1'($urandom);
         wr(3'd0, 8'(dv));
         wr(3'd2, ctl(1,1,pe,po,0,0,0,0));
         wr(3'd5, dat);
         cnt = 0;
         v = 8'd0;
         while (v[2] !== 1'b1 && cnt < 3000) begin @(negedge clk); peek(3'd4, v); cnt++; end
         chk("R6 loopback ready", v[2], 1'b1);
         chk("R8 loopback no errors", v[6:4], 3'd0);
         rdreg(3'd5, v); chk("R3 loopback data", v, dat);
         clks(16 * dv * 2);
      end
      loop = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule